// File: doc/BRIEF.md
# Display Timing Generator with Shadowed Configuration

The block drives the sync, data-enable and pixel-coordinate signals of a parallel display port. Each line and each frame consists of four segments in a fixed order: sync pulse, back porch, active region and front porch. The active size, the porch lengths and the pulse widths are all programmable. Software writes these values, together with a frame-buffer base address and the signal polarities, into a working register set. The counters read only a shadow copy of those values. The shadow copy is refreshed when the block starts running, or at the start of vertical blank while a load request is pending.

Stopping is synchronised to the frame. After the enable request is cleared, the current frame runs to its last pixel, and the enable readback stays high until that point. A display-on bit forces every output to its inactive level without disturbing the counters. A sticky vertical-blank status drives an interrupt when its enable bit is set. A software reset is raised through one register address and released through another. While it is held, all state returns to idle.

Top module: `disp_timing_gen`

## Requirements
- R1: After `rst_n` is released, `hsync`, `vsync`, `de`, `pix_x`, `pix_y`, `frame_addr`, `enable_rd`, `vblank_sts`, `irq`, `load_pending` and `reset_active` all read 0.
- R2: While running, each line lasts `hpw + hbp + hact + hfp` cycles and each frame lasts `vpw + vbp + vact + vfp` lines. The line counter resets at each line end, and the row counter advances once per completed line. The horizontal sync pulse covers the first `hpw` cycles of a line. The vertical sync pulse covers the first `vpw` lines of a frame.
- R3: Data enable is active when the line position lies in `[hpw+hbp, hpw+hbp+hact)` and the row lies in `[vpw+vbp, vpw+vbp+vact)`. There, `pix_x`/`pix_y` equal the offsets from the start of that window; elsewhere they are 0.
- R4: Control register (address 0) bit 2 inverts hsync and bit 3 inverts vsync. Bit 4 makes `de` active low. Bit 5 is output on `pclk_fall`. All four take effect only through the shadow copy.
- R5: Writes to size (address 1: hact [11:0], vact [27:16]), horizontal timing (address 2: front porch [7:0], back porch [15:8], pulse [23:16]), vertical timing (address 3, same fields) and buffer address (address 4) do not change the outputs until they are loaded. Writing 1 to control bit 6 sets `load_pending`. At the end of the last active line, the working set is copied into the shadow in one cycle and `load_pending` clears.
- R6: Control bit 0 is the enable request. While idle with the request set, the block copies the working set, starts at line 0 / row 0 and reads `enable_rd`=1. After the request is cleared, the frame in progress completes, and `enable_rd` stays 1 until the clock edge after its final pixel.
- R7: `vblank_sts` sets at the end of the last active line. Writing 1 to bit 0 of address 5 clears it, and a set in the same cycle wins. `irq` is `vblank_sts` gated by bit 0 of address 6.
- R8: Control bit 1 is display-on. While it is 0, `hsync`, `vsync` and `de` sit at their inactive levels and `pix_x`/`pix_y` are 0, while the counters keep running.
- R9: Writing 1 to bit 0 of address 7 raises `reset_active`, and writing 1 to bit 0 of address 8 lowers it. While it is high, every other register and counter is held at its reset value and other writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pclk_fall | output | 1 | Active falling-edge launch select |
| pix_x | output | CNT_W | Column inside the active area |
| pix_y | output | CNT_W | Row inside the active area |
| frame_addr | output | BUF_W | Active frame-buffer base address |
| enable_rd | output | 1 | Enable readback (high while running) |
| vblank_sts | output | 1 | Sticky vertical-blank status |
| irq | output | 1 | Vertical-blank interrupt |
| load_pending | output | 1 | Shadow-load request still waiting |
| reset_active | output | 1 | Software reset held |

## Verification
The hardest situation to reach is a stop request that lands in the middle of a frame. The same applies to new timing written while an older configuration is still shaping the current frame. A stop request issued during blank can coincide with the last pixel and hide the deferred stop. The stimulus therefore watches the data-enable output and issues the write only while the active window is being drawn. Working values are written without the load bit and left for more than a frame, which shows that they are held back. The load bit is then set, and the reference model predicts the exact edge of the copy at the end of the last active line.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_SIZE   = 4'd1,
    RA_HTIM   = 4'd2,
    RA_VTIM   = 4'd3,
    RA_BUF    = 4'd4,
    RA_STAT   = 4'd5,
    RA_IRQEN  = 4'd6,
    RA_RSTSET = 4'd7,
    RA_RSTCLR = 4'd8
  } reg_addr_e;

  localparam int CB_EN   = 0;
  localparam int CB_ON   = 1;
  localparam int CB_HINV = 2;
  localparam int CB_VINV = 3;
  localparam int CB_DELO = 4;
  localparam int CB_FALL = 5;
  localparam int CB_LOAD = 6;

  localparam int SIZE_V_LSB = 16;
  localparam int TIM_BP_LSB = 8;
  localparam int TIM_PW_LSB = 16;

  function automatic logic [31:0] span_total(logic [31:0] pw, logic [31:0] bp,
                                             logic [31:0] act, logic [31:0] fp);
    return pw + bp + act + fp;
  endfunction

  function automatic logic in_span(logic [31:0] pos, logic [31:0] start, logic [31:0] len);
    return (pos >= start) && (pos < start + len);
  endfunction

  function automatic logic is_last(logic [31:0] pos, logic [31:0] total);
    return (pos + 32'd1) >= total;
  endfunction

endpackage

// File: rtl/disp_regs.sv
module disp_regs
  import disp_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int POR_W = 8,
  parameter int BUF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [BUF_W-1:0] wr_data,
  input  logic             start_evt,
  input  logic             vb_evt,
  output logic             srst,
  output logic             en_req,
  output logic             disp_on,
  output logic             load_req,
  output logic             vb_sts,
  output logic             irq_en,
  output logic [CNT_W-1:0] sh_hact,
  output logic [CNT_W-1:0] sh_vact,
  output logic [POR_W-1:0] sh_hfp,
  output logic [POR_W-1:0] sh_hbp,
  output logic [POR_W-1:0] sh_hpw,
  output logic [POR_W-1:0] sh_vfp,
  output logic [POR_W-1:0] sh_vbp,
  output logic [POR_W-1:0] sh_vpw,
  output logic [3:0]       sh_pol,
  output logic [BUF_W-1:0] sh_buf
);

  logic [CNT_W-1:0] w_hact, w_vact;
  logic [POR_W-1:0] w_hfp, w_hbp, w_hpw, w_vfp, w_vbp, w_vpw;
  logic [3:0]       w_pol;
  logic [BUF_W-1:0] w_buf;
  logic             srst_q, en_q, on_q, load_q, sts_q, ie_q;

  logic wr_ctrl, wr_size, wr_htim, wr_vtim, wr_buf, wr_stat, wr_ie, wr_rset, wr_rclr;
  logic shadow_take;

  assign wr_ctrl = wr_en && (wr_addr == RA_CTRL);
  assign wr_size = wr_en && (wr_addr == RA_SIZE);
  assign wr_htim = wr_en && (wr_addr == RA_HTIM);
  assign wr_vtim = wr_en && (wr_addr == RA_VTIM);
  assign wr_buf  = wr_en && (wr_addr == RA_BUF);
  assign wr_stat = wr_en && (wr_addr == RA_STAT);
  assign wr_ie   = wr_en && (wr_addr == RA_IRQEN);
  assign wr_rset = wr_en && (wr_addr == RA_RSTSET) && wr_data[0];
  assign wr_rclr = wr_en && (wr_addr == RA_RSTCLR) && wr_data[0];

  assign shadow_take = start_evt || (vb_evt && load_q);

  // software reset flag: own set and clear aliases, clear wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       srst_q <= 1'b0;
    else if (wr_rclr) srst_q <= 1'b0;
    else if (wr_rset) srst_q <= 1'b1;
  end

  // working registers, control and status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; on_q <= 1'b0; load_q <= 1'b0; sts_q <= 1'b0; ie_q <= 1'b0;
      w_pol <= '0; w_hact <= '0; w_vact <= '0; w_buf <= '0;
      w_hfp <= '0; w_hbp <= '0; w_hpw <= '0; w_vfp <= '0; w_vbp <= '0; w_vpw <= '0;
    end else if (srst_q) begin
      en_q <= 1'b0; on_q <= 1'b0; load_q <= 1'b0; sts_q <= 1'b0; ie_q <= 1'b0;
      w_pol <= '0; w_hact <= '0; w_vact <= '0; w_buf <= '0;
      w_hfp <= '0; w_hbp <= '0; w_hpw <= '0; w_vfp <= '0; w_vbp <= '0; w_vpw <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wr_data[CB_EN];
        on_q  <= wr_data[CB_ON];
        w_pol <= {wr_data[CB_FALL], wr_data[CB_DELO], wr_data[CB_VINV], wr_data[CB_HINV]};
      end
      if (wr_ctrl && wr_data[CB_LOAD]) load_q <= 1'b1;
      else if (start_evt || vb_evt)    load_q <= 1'b0;
      if (wr_size) begin
        w_hact <= wr_data[0 +: CNT_W];
        w_vact <= wr_data[SIZE_V_LSB +: CNT_W];
      end
      if (wr_htim) begin
        w_hfp <= wr_data[0 +: POR_W];
        w_hbp <= wr_data[TIM_BP_LSB +: POR_W];
        w_hpw <= wr_data[TIM_PW_LSB +: POR_W];
      end
      if (wr_vtim) begin
        w_vfp <= wr_data[0 +: POR_W];
        w_vbp <= wr_data[TIM_BP_LSB +: POR_W];
        w_vpw <= wr_data[TIM_PW_LSB +: POR_W];
      end
      if (wr_buf) w_buf <= wr_data;
      if (wr_ie)  ie_q  <= wr_data[0];
      if (vb_evt)                     sts_q <= 1'b1;
      else if (wr_stat && wr_data[0]) sts_q <= 1'b0;
    end
  end

  // active (shadow) set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_hact <= '0; sh_vact <= '0; sh_buf <= '0; sh_pol <= '0;
      sh_hfp <= '0; sh_hbp <= '0; sh_hpw <= '0; sh_vfp <= '0; sh_vbp <= '0; sh_vpw <= '0;
    end else if (srst_q) begin
      sh_hact <= '0; sh_vact <= '0; sh_buf <= '0; sh_pol <= '0;
      sh_hfp <= '0; sh_hbp <= '0; sh_hpw <= '0; sh_vfp <= '0; sh_vbp <= '0; sh_vpw <= '0;
    end else if (shadow_take) begin
      sh_hact <= w_hact; sh_vact <= w_vact; sh_buf <= w_buf; sh_pol <= w_pol;
      sh_hfp <= w_hfp; sh_hbp <= w_hbp; sh_hpw <= w_hpw;
      sh_vfp <= w_vfp; sh_vbp <= w_vbp; sh_vpw <= w_vpw;
    end
  end

  assign srst     = srst_q;
  assign en_req   = en_q;
  assign disp_on  = on_q;
  assign load_req = load_q;
  assign vb_sts   = sts_q;
  assign irq_en   = ie_q;

  AST_LOAD_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_evt && load_q && !srst_q && !(wr_ctrl && wr_data[CB_LOAD])) |=> !load_q); // R5
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_evt && !(vb_evt && load_q) && !srst_q)
      |=> ($stable(sh_buf) && $stable(sh_hact) && $stable(sh_vact) && $stable(sh_pol)
           && $stable(sh_hpw) && $stable(sh_vpw))); // R5
  AST_VB_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (vb_evt && !srst_q) |=> sts_q); // R7

endmodule

// File: rtl/disp_counter.sv
module disp_counter
  import disp_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int POR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srst,
  input  logic             en_req,
  input  logic [CNT_W-1:0] hact,
  input  logic [CNT_W-1:0] vact,
  input  logic [POR_W-1:0] hfp,
  input  logic [POR_W-1:0] hbp,
  input  logic [POR_W-1:0] hpw,
  input  logic [POR_W-1:0] vfp,
  input  logic [POR_W-1:0] vbp,
  input  logic [POR_W-1:0] vpw,
  output logic             running,
  output logic [CNT_W-1:0] h_pos,
  output logic [CNT_W-1:0] v_pos,
  output logic             start_evt,
  output logic             vb_evt,
  output logic             frame_last
);

  logic [CNT_W-1:0] h_q, v_q;
  logic             run_q;
  logic [31:0]      htot, vtot, vact_end;
  logic             h_last, v_last, stop_evt;

  assign htot     = span_total(32'(hpw), 32'(hbp), 32'(hact), 32'(hfp));
  assign vtot     = span_total(32'(vpw), 32'(vbp), 32'(vact), 32'(vfp));
  assign vact_end = 32'(vpw) + 32'(vbp) + 32'(vact);
  assign h_last   = is_last(32'(h_q), htot);
  assign v_last   = is_last(32'(v_q), vtot);

  assign start_evt  = !run_q && en_req;
  assign frame_last = run_q && h_last && v_last;
  assign stop_evt   = frame_last && !en_req;
  assign vb_evt     = run_q && h_last && ((32'(v_q) + 32'd1) == vact_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; h_q <= '0; v_q <= '0;
    end else if (srst) begin
      run_q <= 1'b0; h_q <= '0; v_q <= '0;
    end else if (start_evt) begin
      run_q <= 1'b1; h_q <= '0; v_q <= '0;
    end else if (stop_evt) begin
      run_q <= 1'b0; h_q <= '0; v_q <= '0;
    end else if (run_q) begin
      if (h_last) begin
        h_q <= '0;
        v_q <= v_last ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  assign running = run_q;
  assign h_pos   = h_q;
  assign v_pos   = v_q;

  AST_STOP_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_q) |-> ($past(frame_last) || $past(srst))); // R6
  AST_H_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && htot != 32'd0) |-> (32'(h_q) < htot)); // R2

endmodule

// File: rtl/disp_out.sv
module disp_out
  import disp_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int POR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             disp_on,
  input  logic [CNT_W-1:0] h_pos,
  input  logic [CNT_W-1:0] v_pos,
  input  logic [CNT_W-1:0] hact,
  input  logic [CNT_W-1:0] vact,
  input  logic [POR_W-1:0] hbp,
  input  logic [POR_W-1:0] hpw,
  input  logic [POR_W-1:0] vbp,
  input  logic [POR_W-1:0] vpw,
  input  logic             hs_inv,
  input  logic             vs_inv,
  input  logic             de_low,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] pix_y
);

  logic        act, hs_raw, vs_raw, in_win;
  logic [31:0] hx0, vy0, dx, dy;

  assign act    = running && disp_on;
  assign hx0    = 32'(hpw) + 32'(hbp);
  assign vy0    = 32'(vpw) + 32'(vbp);
  assign hs_raw = 32'(h_pos) < 32'(hpw);
  assign vs_raw = 32'(v_pos) < 32'(vpw);
  assign in_win = act && in_span(32'(h_pos), hx0, 32'(hact)) && in_span(32'(v_pos), vy0, 32'(vact));
  assign dx     = 32'(h_pos) - hx0;
  assign dy     = 32'(v_pos) - vy0;

  assign hsync = hs_inv ^ (act && hs_raw);
  assign vsync = vs_inv ^ (act && vs_raw);
  assign de    = de_low ^ in_win;
  assign pix_x = in_win ? dx[CNT_W-1:0] : '0;
  assign pix_y = in_win ? dy[CNT_W-1:0] : '0;

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_on |-> (hsync == hs_inv && vsync == vs_inv && de == de_low)); // R8
  AST_COORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (de != de_low) |-> (32'(pix_x) < 32'(hact) && 32'(pix_y) < 32'(vact))); // R3

endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import disp_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int POR_W = 8,
  parameter int BUF_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [BUF_W-1:0] wr_data,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic             pclk_fall,
  output logic [CNT_W-1:0] pix_x,
  output logic [CNT_W-1:0] pix_y,
  output logic [BUF_W-1:0] frame_addr,
  output logic             enable_rd,
  output logic             vblank_sts,
  output logic             irq,
  output logic             load_pending,
  output logic             reset_active
);

  logic             srst, en_req, disp_on, load_req, vb_sts, irq_en;
  logic [CNT_W-1:0] sh_hact, sh_vact, h_pos, v_pos;
  logic [POR_W-1:0] sh_hfp, sh_hbp, sh_hpw, sh_vfp, sh_vbp, sh_vpw;
  logic [3:0]       sh_pol;
  logic [BUF_W-1:0] sh_buf;
  logic             running, start_evt, vb_evt, frame_last;

  disp_regs #(.CNT_W(CNT_W), .POR_W(POR_W), .BUF_W(BUF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_evt(start_evt), .vb_evt(vb_evt),
    .srst(srst), .en_req(en_req), .disp_on(disp_on), .load_req(load_req),
    .vb_sts(vb_sts), .irq_en(irq_en),
    .sh_hact(sh_hact), .sh_vact(sh_vact),
    .sh_hfp(sh_hfp), .sh_hbp(sh_hbp), .sh_hpw(sh_hpw),
    .sh_vfp(sh_vfp), .sh_vbp(sh_vbp), .sh_vpw(sh_vpw),
    .sh_pol(sh_pol), .sh_buf(sh_buf)
  );

  disp_counter #(.CNT_W(CNT_W), .POR_W(POR_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .srst(srst), .en_req(en_req),
    .hact(sh_hact), .vact(sh_vact),
    .hfp(sh_hfp), .hbp(sh_hbp), .hpw(sh_hpw),
    .vfp(sh_vfp), .vbp(sh_vbp), .vpw(sh_vpw),
    .running(running), .h_pos(h_pos), .v_pos(v_pos),
    .start_evt(start_evt), .vb_evt(vb_evt), .frame_last(frame_last)
  );

  disp_out #(.CNT_W(CNT_W), .POR_W(POR_W)) u_out (
    .clk(clk), .rst_n(rst_n), .running(running), .disp_on(disp_on),
    .h_pos(h_pos), .v_pos(v_pos), .hact(sh_hact), .vact(sh_vact),
    .hbp(sh_hbp), .hpw(sh_hpw), .vbp(sh_vbp), .vpw(sh_vpw),
    .hs_inv(sh_pol[0]), .vs_inv(sh_pol[1]), .de_low(sh_pol[2]),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_x(pix_x), .pix_y(pix_y)
  );

  assign pclk_fall    = sh_pol[3];
  assign frame_addr   = sh_buf;
  assign enable_rd    = running;
  assign vblank_sts   = vb_sts;
  assign irq          = vb_sts && irq_en;
  assign load_pending = load_req;
  assign reset_active = srst;

  AST_RUN_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable_rd) |-> $past(en_req)); // R6
  AST_STOP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_last && !en_req && !srst) |=> !enable_rd); // R6

endmodule

// File: tb/sim_disp_timing_gen.sv
`timescale 1ns/1ps
module sim_disp_timing_gen;

  localparam int CNT_W = 12;
  localparam int POR_W = 8;
  localparam int BUF_W = 32;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [3:0]       wr_addr = '0;
  logic [BUF_W-1:0] wr_data = '0;
  logic             hsync, vsync, de, pclk_fall, enable_rd, vblank_sts, irq, load_pending, reset_active;
  logic [CNT_W-1:0] pix_x, pix_y;
  logic [BUF_W-1:0] frame_addr;

  always #2 clk = ~clk;

  disp_timing_gen #(.CNT_W(CNT_W), .POR_W(POR_W), .BUF_W(BUF_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk_fall(pclk_fall),
    .pix_x(pix_x), .pix_y(pix_y), .frame_addr(frame_addr),
    .enable_rd(enable_rd), .vblank_sts(vblank_sts), .irq(irq),
    .load_pending(load_pending), .reset_active(reset_active)
  );

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  typedef struct {
    int hact, vact, hfp, hbp, hpw, vfp, vbp, vpw;
    logic [31:0] base;
    bit hi, vi, dl, fl;
  } cfg_t;

  cfg_t wk, sh;
  bit m_srst, m_en, m_on, m_ld, m_sts, m_ie, m_run;
  int m_h, m_v;

  function automatic cfg_t cfg_zero();
    cfg_t c;
    c.hact = 0; c.vact = 0; c.hfp = 0; c.hbp = 0; c.hpw = 0;
    c.vfp = 0; c.vbp = 0; c.vpw = 0; c.base = '0;
    c.hi = 0; c.vi = 0; c.dl = 0; c.fl = 0;
    return c;
  endfunction

  task automatic model_clear();
    wk = cfg_zero(); sh = cfg_zero();
    m_en = 0; m_on = 0; m_ld = 0; m_sts = 0; m_ie = 0; m_run = 0; m_h = 0; m_v = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      model_clear();
      m_srst = 0;
    end else if (m_srst) begin
      model_clear();
      if (wr_en && wr_addr == 4'd8 && wr_data[0]) m_srst = 0;
    end else begin
      int htot, vtot;
      bit hl, vl, vb, start, stop, ld_old;
      cfg_t wk_old;
      htot   = sh.hpw + sh.hbp + sh.hact + sh.hfp;
      vtot   = sh.vpw + sh.vbp + sh.vact + sh.vfp;
      hl     = (m_h + 1) >= htot;
      vl     = (m_v + 1) >= vtot;
      vb     = m_run && hl && ((m_v + 1) == sh.vpw + sh.vbp + sh.vact);
      start  = !m_run && m_en;
      stop   = m_run && !m_en && hl && vl;
      wk_old = wk;
      ld_old = m_ld;
      if (start) begin m_run = 1; m_h = 0; m_v = 0; end
      else if (stop) begin m_run = 0; m_h = 0; m_v = 0; end
      else if (m_run) begin
        if (hl) begin m_h = 0; m_v = vl ? 0 : m_v + 1; end
        else m_h = m_h + 1;
      end
      if (start || (vb && ld_old)) sh = wk_old;
      if (start || vb) m_ld = 0;
      if (wr_en && wr_addr == 4'd5 && wr_data[0]) m_sts = 0;
      if (vb) m_sts = 1;
      if (wr_en) begin
        case (wr_addr)
          4'd0: begin
            m_en = wr_data[0]; m_on = wr_data[1];
            wk.hi = wr_data[2]; wk.vi = wr_data[3]; wk.dl = wr_data[4]; wk.fl = wr_data[5];
            if (wr_data[6]) m_ld = 1;
          end
          4'd1: begin wk.hact = int'(wr_data[11:0]); wk.vact = int'(wr_data[27:16]); end
          4'd2: begin wk.hfp = int'(wr_data[7:0]); wk.hbp = int'(wr_data[15:8]); wk.hpw = int'(wr_data[23:16]); end
          4'd3: begin wk.vfp = int'(wr_data[7:0]); wk.vbp = int'(wr_data[15:8]); wk.vpw = int'(wr_data[23:16]); end
          4'd4: wk.base = wr_data;
          4'd6: m_ie = wr_data[0];
          4'd7: if (wr_data[0]) m_srst = 1;
          default: ;
        endcase
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      bit act, win;
      int x0, y0, ex, ey;
      act = m_run && m_on;
      x0  = sh.hpw + sh.hbp;
      y0  = sh.vpw + sh.vbp;
      win = act && m_h >= x0 && m_h < x0 + sh.hact && m_v >= y0 && m_v < y0 + sh.vact;
      ex  = win ? m_h - x0 : 0;
      ey  = win ? m_v - y0 : 0;
      chk(hsync === (sh.hi ^ (act && m_h < sh.hpw)), "R2 R4 R8", "hsync", hsync, sh.hi ^ (act && m_h < sh.hpw));
      chk(vsync === (sh.vi ^ (act && m_v < sh.vpw)), "R2 R4 R8", "vsync", vsync, sh.vi ^ (act && m_v < sh.vpw));
      chk(de === (sh.dl ^ win), "R3 R4 R8", "de", de, sh.dl ^ win);
      chk(int'(pix_x) == ex, "R3", "pix_x", pix_x, ex);
      chk(int'(pix_y) == ey, "R3", "pix_y", pix_y, ey);
      chk(pclk_fall === sh.fl, "R4", "pclk_fall", pclk_fall, sh.fl);
      chk(frame_addr === sh.base, "R5", "frame_addr", frame_addr, sh.base);
      chk(load_pending === m_ld, "R5", "load_pending", load_pending, m_ld);
      chk(enable_rd === m_run, "R6", "enable_rd", enable_rd, m_run);
      chk(vblank_sts === m_sts, "R7", "vblank_sts", vblank_sts, m_sts);
      chk(irq === (m_sts && m_ie), "R7", "irq", irq, m_sts && m_ie);
      chk(reset_active === m_srst, "R9", "reset_active", reset_active, m_srst);
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] ctl(bit en, bit on, bit hi, bit vi, bit dl, bit fl, bit ld);
    return {25'd0, ld, fl, dl, vi, hi, on, en};
  endfunction

  function automatic logic [31:0] tim(int fp, int bp, int pw);
    return {8'd0, 8'(pw), 8'(bp), 8'(fp)};
  endfunction

  initial begin
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hsync === 1'b0 && vsync === 1'b0 && de === 1'b0, "R1", "syncs/de", {hsync, vsync, de}, 0);
    chk(pix_x == 0 && pix_y == 0 && frame_addr == 0, "R1", "coords/addr", frame_addr, 0);
    chk(enable_rd === 1'b0 && vblank_sts === 1'b0 && irq === 1'b0, "R1", "status", {enable_rd, vblank_sts, irq}, 0);
    chk(load_pending === 1'b0 && reset_active === 1'b0, "R1", "load/reset", {load_pending, reset_active}, 0);
    cmp_on = 1'b1;

    // R2 R3: first configuration and start (R6 start loads shadow)
    wr(4'd1, {4'd0, 12'd3, 4'd0, 12'd4});
    wr(4'd2, tim(2, 1, 2));
    wr(4'd3, tim(1, 1, 1));
    wr(4'd4, 32'h0000_1000);
    wr(4'd6, 32'd1);
    wr(4'd0, ctl(1, 1, 0, 0, 0, 0, 0));
    idle(130);

    // R5: working writes without load are held back
    wr(4'd1, {4'd0, 12'd2, 4'd0, 12'd5});
    wr(4'd2, tim(1, 2, 1));
    wr(4'd3, tim(1, 1, 1));
    wr(4'd4, 32'h0000_2000);
    idle(60);
    chk(frame_addr === 32'h0000_1000, "R5", "addr before load", frame_addr, 32'h1000);
    // R5 R4: load with inverted syncs
    wr(4'd0, ctl(1, 1, 1, 1, 0, 0, 1));
    chk(load_pending === 1'b1, "R5", "load pending after request", load_pending, 1);
    idle(150);
    chk(frame_addr === 32'h0000_2000 && load_pending === 1'b0, "R5", "addr after load", frame_addr, 32'h2000);

    // R7: clear status, then it sets again
    wr(4'd5, 32'd1);
    idle(30);

    // R8: display off gates outputs
    wr(4'd0, ctl(1, 0, 1, 1, 0, 0, 0));
    idle(60);
    wr(4'd0, ctl(1, 1, 1, 1, 0, 0, 0));
    idle(20);

    // R4: active-low data enable and falling-edge launch
    wr(4'd0, ctl(1, 1, 0, 0, 1, 1, 1));
    idle(120);
    chk(pclk_fall === 1'b1, "R4", "pclk_fall loaded", pclk_fall, 1);

    // R6: stop request placed inside the active window
    while (de !== 1'b0) @(negedge clk);
    wr(4'd0, ctl(0, 1, 0, 0, 1, 1, 0));
    chk(enable_rd === 1'b1, "R6", "enable still reads set", enable_rd, 1);
    idle(150);
    chk(enable_rd === 1'b0, "R6", "enable cleared after frame", enable_rd, 0);

    // R9: restart then software reset through the two aliases
    wr(4'd0, ctl(1, 1, 0, 0, 0, 0, 0));
    idle(40);
    wr(4'd7, 32'd1);
    idle(3);
    chk(reset_active === 1'b1 && enable_rd === 1'b0, "R9", "reset held, idle", {reset_active, enable_rd}, 2);
    wr(4'd0, ctl(1, 1, 0, 0, 0, 0, 0));
    idle(3);
    chk(enable_rd === 1'b0, "R9", "write ignored during reset", enable_rd, 0);
    wr(4'd8, 32'd1);
    idle(3);
    chk(reset_active === 1'b0 && frame_addr === 32'd0 && vblank_sts === 1'b0, "R9", "after release",
        frame_addr, 0);
    idle(5);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule